// File: doc/BRIEF.md
# Triggered Digital Pattern Generator

This block plays a stored sequence of 32-bit words out onto a parallel output bus. The words sit in a sample buffer outside the block; the block presents an address on a read port and takes the word back on the same cycle. Software sets up the rate, the word width, the pacing source, single-shot or repeat playback, and whether a trigger gates the start. It then pulses `go`.

Pacing has two sources. The internal source counts pulses of a 20 MHz base tick, so an output period is a whole number of 50 ns ticks. The external source moves to the next word only when the receiver acknowledges the current one. The output side uses a request/acknowledge pair, so in external mode no word is lost. In single-shot mode the block stops after the programmed number of words. It holds the final word, raises `done` and returns to idle. In repeat mode it wraps from the last word back to the first and keeps going until reset.

Configuration inputs are expected to stay stable while the block is armed or running.

Top module: `trig_pattern_gen`

## Requirements
- R1: After reset, `do_data` is 0, and `do_req`, `done` and `buf_addr` are all 0.
- R2: With `cfg_trig_en`=0, a `go` pulse seen in idle starts playback on that same clock edge. After the edge, `do_data` holds buffer word 0 and `do_req` is 1.
- R3: With `cfg_trig_en`=1, a `go` pulse in idle only arms the block. Playback starts on the first clock edge at which `trig_in` is 1 after having been 0 on the edge before. A trigger edge while idle has no effect, and a trigger held high from before arming does not count.
- R4: In internal pacing (`cfg_ext_pace`=0), each word stays on `do_data` for exactly N pulses of `tick_in` counted after the word loads, where N is `cfg_div`. A `cfg_div` of 0 acts as 1.
- R5: In external pacing (`cfg_ext_pace`=1), `tick_in` is ignored. A word and `do_req` are held until `do_ack` is sampled high, and the next word appears after that same edge.
- R6: In single-shot mode (`cfg_repeat`=0), the pacing event that ends the last of `cfg_count` words has three effects: `do_req` drops, `done` rises, and `do_data` keeps the last word. The next `go` clears `done` and starts again from word 0.
- R7: In repeat mode (`cfg_repeat`=1), the word after the last one is word 0 again, and `done` stays 0.
- R8: `cfg_width` 0 outputs bits 7:0 of the word and `cfg_width` 1 outputs bits 15:0, with all higher output lines driven to 0. `cfg_width` 2 or 3 outputs all 32 bits.
- R9: `buf_addr` always shows the index of the next word to load, and `buf_data` is taken on the same cycle. After word k loads, `buf_addr` is k+1, or 0 after the last word.
- R10: A `go` pulse while the block is running has no effect on the output sequence.
- R11: A `cfg_count` of 0 plays the full buffer depth (`DEPTH` words).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | One-cycle pulse per 50 ns base tick |
| cfg_div | input | DIV_W | Base ticks per output word |
| cfg_width | input | 2 | Width mode: 0 = 8 bit, 1 = 16 bit, 2/3 = 32 bit |
| cfg_ext_pace | input | 1 | 1 = advance on `do_ack`, 0 = internal divider |
| cfg_repeat | input | 1 | 1 = endless wrap-around playback |
| cfg_trig_en | input | 1 | 1 = start waits for a rising trigger |
| cfg_count | input | AW+1 | Words per pass, 0 = DEPTH |
| go | input | 1 | Start (or arm) pulse |
| trig_in | input | 1 | Start trigger |
| buf_addr | output | AW | Buffer read address |
| buf_data | input | DATA_W | Buffer read data, same cycle |
| do_data | output | DATA_W | Output word |
| do_req | output | 1 | A word is presented and not yet consumed |
| do_ack | input | 1 | External acknowledge / pacing strobe |
| done | output | 1 | Single-shot pass finished |

## Verification
The bench targets word-boundary timing. A divider off by one would release each word one tick early or late. A zero divisor might hang the block or hold a word forever. The end of a pass is checked closely. A design that counts words wrongly would emit an extra word, or clear the last word instead of holding it, or raise `done` in repeat mode rather than wrapping to word 0. The trigger cases separate an edge from a level: a design that tests the level would start from a trigger that was already high when the block armed. An acknowledge-paced run with ticks applied shows whether the external path leaks internal pacing.

// File: rtl/pg_pkg.sv
package pg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_ARMED = 2'b01,
      ST_RUN   = 2'b10
   } pg_state_t;

   localparam logic [1:0] WMODE_8  = 2'b00;
   localparam logic [1:0] WMODE_16 = 2'b01;
endpackage

// File: rtl/pg_pacer.sv
module pg_pacer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             restart,
   input  logic             tick_in,
   input  logic [DIV_W-1:0] div,
   input  logic             ext_mode,
   input  logic             ack,
   output logic             adv
);
   localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_eff;
   logic             int_hit;

   assign div_eff = (div == '0) ? DIV_ONE : div;
   assign int_hit = tick_in && (cnt == div_eff - DIV_ONE);
   assign adv     = active && (ext_mode ? ack : int_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || adv || !active)
         cnt <= '0;
      else if (!ext_mode && tick_in)
         cnt <= cnt + DIV_ONE;
   end

   p_cnt_below_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !ext_mode) |-> (cnt < div_eff));

   p_ext_ignores_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ext_mode && !ack) |-> !adv);
endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
   import pg_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          trig_in,
   input  logic          trig_en,
   input  logic          rep,
   input  logic [AW:0]   count,
   input  logic          adv,
   output logic          load,
   output logic          req,
   output logic          done,
   output logic [AW-1:0] addr
);
   localparam logic [AW:0] FULL    = (AW+1)'(DEPTH);
   localparam logic [AW:0] ONE_EXT = (AW+1)'(1);

   pg_state_t   st;
   logic        trig_q;
   logic        trig_rise;
   logic        start;
   logic        finish;
   logic [AW-1:0] idx;
   logic [AW:0] idx_inc;
   logic [AW:0] count_eff;
   logic [AW-1:0] idx_next;
   logic        at_last;

   assign count_eff = (count == '0) ? FULL : count;
   assign idx_inc   = {1'b0, idx} + ONE_EXT;
   assign idx_next  = (idx_inc >= count_eff) ? '0 : idx_inc[AW-1:0];
   assign trig_rise = trig_in && !trig_q;
   assign at_last   = (idx == '0);

   assign start  = ((st == ST_IDLE) && go && !trig_en) ||
                   ((st == ST_ARMED) && trig_rise);
   assign finish = (st == ST_RUN) && adv && at_last && !rep;
   assign load   = start || ((st == ST_RUN) && adv && (!at_last || rep));
   assign req    = (st == ST_RUN);
   assign addr   = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trig_q <= 1'b0;
      else
         trig_q <= trig_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         idx  <= '0;
         done <= 1'b0;
      end else begin
         if (load)
            idx <= idx_next;
         case (st)
            ST_IDLE: begin
               if (go) begin
                  done <= 1'b0;
                  st   <= trig_en ? ST_ARMED : ST_RUN;
               end
            end
            ST_ARMED: begin
               if (trig_rise)
                  st <= ST_RUN;
            end
            ST_RUN: begin
               if (finish) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   p_addr_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, addr} < count_eff));

   p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req);

   p_go_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !adv) |=> ($stable(addr) && req));

   p_repeat_no_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && rep) |=> !done);
endmodule

// File: rtl/pg_formatter.sv
module pg_formatter
   import pg_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        width,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int NLANE = DATA_W / 8;

   logic [DATA_W-1:0] masked;

   for (genvar b = 0; b < NLANE; b++) begin : g_lane
      logic keep;
      if (b == 0) begin : g_low
         assign keep = 1'b1;
      end else if (b == 1) begin : g_mid
         assign keep = (width != WMODE_8);
      end else begin : g_high
         assign keep = (width != WMODE_8) && (width != WMODE_16);
      end
      assign masked[8*b +: 8] = keep ? din[8*b +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= '0;
      else if (load)
         dout <= masked;
   end

   p_narrow_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (width == WMODE_8)) |=> (dout[DATA_W-1:8] == '0));

   p_hold_without_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(dout));
endmodule

// File: rtl/trig_pattern_gen.sv
module trig_pattern_gen #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 1024,
   parameter int DIV_W  = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_ext_pace,
   input  logic              cfg_repeat,
   input  logic              cfg_trig_en,
   input  logic [AW:0]       cfg_count,
   input  logic              go,
   input  logic              trig_in,
   output logic [AW-1:0]     buf_addr,
   input  logic [DATA_W-1:0] buf_data,
   output logic [DATA_W-1:0] do_data,
   output logic              do_req,
   input  logic              do_ack,
   output logic              done
);
   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 32");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic load;
   logic adv;

   pg_sequencer #(.DEPTH(DEPTH), .AW(AW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .trig_in (trig_in),
      .trig_en (cfg_trig_en),
      .rep     (cfg_repeat),
      .count   (cfg_count),
      .adv     (adv),
      .load    (load),
      .req     (do_req),
      .done    (done),
      .addr    (buf_addr)
   );

   pg_pacer #(.DIV_W(DIV_W)) u_pace (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (do_req),
      .restart  (load),
      .tick_in  (tick_in),
      .div      (cfg_div),
      .ext_mode (cfg_ext_pace),
      .ack      (do_ack),
      .adv      (adv)
   );

   pg_formatter #(.DATA_W(DATA_W)) u_fmt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .width (cfg_width),
      .din   (buf_data),
      .dout  (do_data)
   );

   p_ext_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (do_req && cfg_ext_pace && !do_ack) |=> ($stable(do_data) && do_req));

   p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && do_req));
endmodule

// File: tb/sim_trig_pattern_gen.sv
module sim_trig_pattern_gen;
   localparam int DATA_W = 32;
   localparam int DEPTH  = 1024;
   localparam int DIV_W  = 16;
   localparam int AW     = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_in = 1'b0;
   logic [DIV_W-1:0]  cfg_div = '0;
   logic [1:0]        cfg_width = 2'd2;
   logic              cfg_ext_pace = 1'b0;
   logic              cfg_repeat = 1'b0;
   logic              cfg_trig_en = 1'b0;
   logic [AW:0]       cfg_count = '0;
   logic              go = 1'b0;
   logic              trig_in = 1'b0;
   logic [AW-1:0]     buf_addr;
   logic [DATA_W-1:0] buf_data;
   logic [DATA_W-1:0] do_data;
   logic              do_req;
   logic              do_ack = 1'b0;
   logic              done;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   function automatic logic [31:0] pat(input int i);
      logic [31:0] v;
      v = 32'h9E3779B9 * (i + 1);
      return v ^ 32'hA5C3_0F1E;
   endfunction

   assign buf_data = pat(int'(buf_addr));

   trig_pattern_gen #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cfg_div(cfg_div),
      .cfg_width(cfg_width), .cfg_ext_pace(cfg_ext_pace), .cfg_repeat(cfg_repeat),
      .cfg_trig_en(cfg_trig_en), .cfg_count(cfg_count), .go(go), .trig_in(trig_in),
      .buf_addr(buf_addr), .buf_data(buf_data), .do_data(do_data), .do_req(do_req),
      .do_ack(do_ack), .done(done)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic tick();
      tick_in = 1'b1; cyc(); tick_in = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulse_go();
      go = 1'b1; cyc(); go = 1'b0;
   endtask

   task automatic pulse_ack();
      do_ack = 1'b1; cyc(); do_ack = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick_in = 1'b0; go = 1'b0; trig_in = 1'b0; do_ack = 1'b0;
      cyc(); cyc();
      rst_n = 1'b1; cyc();
   endtask

   task automatic set_cfg(input int dv, input int w, input bit ext, input bit rp,
                          input bit te, input int cnt);
      cfg_div = DIV_W'(dv); cfg_width = 2'(w); cfg_ext_pace = ext;
      cfg_repeat = rp; cfg_trig_en = te; cfg_count = (AW+1)'(cnt);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 data", do_data, 32'h0);
      chk("R1 req", {31'b0, do_req}, 32'd0);
      chk("R1 done", {31'b0, done}, 32'd0);
      chk("R1 addr", 32'(buf_addr), 32'd0);
   endtask

   task automatic t_single();
      set_cfg(3, 2, 0, 0, 0, 2);
      pulse_go();
      chk("R2 first word", do_data, pat(0));
      chk("R2 req", {31'b0, do_req}, 32'd1);
      chk("R9 addr next", 32'(buf_addr), 32'd1);
      ticks(2); cyc();
      chk("R4 held 2 ticks", do_data, pat(0));
      tick();
      chk("R4 advance on 3rd tick", do_data, pat(1));
      chk("R9 addr wraps", 32'(buf_addr), 32'd0);
      ticks(2);
      chk("R6 req before end", {31'b0, do_req}, 32'd1);
      tick();
      chk("R6 req drops", {31'b0, do_req}, 32'd0);
      chk("R6 done", {31'b0, done}, 32'd1);
      chk("R6 last word held", do_data, pat(1));
      ticks(4);
      chk("R6 still held", do_data, pat(1));
      pulse_go();
      chk("R6 restart clears done", {31'b0, done}, 32'd0);
      chk("R6 restart word0", do_data, pat(0));
      ticks(6);
      chk("R6 second pass done", {31'b0, done}, 32'd1);
   endtask

   task automatic t_div0();
      set_cfg(0, 2, 0, 0, 0, 3);
      pulse_go();
      tick();
      chk("R4 div0 as 1", do_data, pat(1));
      tick();
      chk("R4 div0 word2", do_data, pat(2));
      tick();
      chk("R4 div0 done", {31'b0, done}, 32'd1);
   endtask

   task automatic t_ext();
      set_cfg(1, 2, 1, 0, 0, 2);
      pulse_go();
      ticks(3);
      chk("R5 ticks ignored", do_data, pat(0));
      chk("R5 req held", {31'b0, do_req}, 32'd1);
      pulse_ack();
      chk("R5 ack advances", do_data, pat(1));
      cyc(); cyc();
      chk("R5 hold without ack", do_data, pat(1));
      pulse_ack();
      chk("R5 last ack ends", {31'b0, done}, 32'd1);
      chk("R5 req off", {31'b0, do_req}, 32'd0);
   endtask

   task automatic t_repeat();
      set_cfg(1, 2, 0, 1, 0, 3);
      pulse_go();
      tick(); tick();
      chk("R7 word2", do_data, pat(2));
      tick();
      chk("R7 wrap to word0", do_data, pat(0));
      chk("R7 no done", {31'b0, done}, 32'd0);
      pulse_go();
      chk("R10 go while running", do_data, pat(0));
      tick();
      chk("R10 sequence continues", do_data, pat(1));
      do_reset();
   endtask

   task automatic t_width();
      set_cfg(1, 0, 0, 0, 0, 1);
      pulse_go();
      chk("R8 8-bit", do_data, pat(0) & 32'h0000_00FF);
      tick();
      cfg_width = 2'd1;
      pulse_go();
      chk("R8 16-bit", do_data, pat(0) & 32'h0000_FFFF);
      tick();
      cfg_width = 2'd3;
      pulse_go();
      chk("R8 code3 full", do_data, pat(0));
      tick();
   endtask

   task automatic t_trig();
      set_cfg(1, 2, 0, 0, 1, 1);
      trig_in = 1'b1; cyc(); trig_in = 1'b0; cyc();
      chk("R3 trigger while idle", {31'b0, do_req}, 32'd0);
      trig_in = 1'b1; cyc();
      pulse_go();
      cyc(); cyc();
      chk("R3 armed level ignored", {31'b0, do_req}, 32'd0);
      trig_in = 1'b0; cyc();
      trig_in = 1'b1; cyc();
      chk("R3 rise starts", {31'b0, do_req}, 32'd1);
      chk("R3 rise word0", do_data, pat(0));
      trig_in = 1'b0;
      tick();
      chk("R3 single word done", {31'b0, done}, 32'd1);
   endtask

   task automatic t_full();
      set_cfg(1, 2, 0, 0, 0, 0);
      pulse_go();
      ticks(DEPTH - 1);
      chk("R11 last index word", do_data, pat(DEPTH - 1));
      chk("R11 still running", {31'b0, do_req}, 32'd1);
      tick();
      chk("R11 done after DEPTH", {31'b0, done}, 32'd1);
   endtask

   initial begin
      t_reset();
      t_single();
      t_div0();
      t_ext();
      t_repeat();
      t_width();
      t_trig();
      t_full();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule